// File: doc/BRIEF.md
# Playback Sample FIFO with Slot Unpacker

This block buffers playback audio for a single output channel. On the host side it accepts 32-bit words, and each word carries two 16-bit samples. On the frame side it hands out one 20-bit slot value for each request. A slot value holds the 16-bit sample left-justified, so the four least significant bits are zero. The low half of each stored word goes out first and the high half goes out second. The word is released from storage only after both halves have been sent.

The block watches how much storage is free and compares it with a level the host selects. When the free space reaches that level it raises a threshold status and a DMA request. The request stays up until the DMA engine acknowledges it with a one-cycle pulse. Two sticky flags record errors: an underrun when the frame side asks for a sample while storage is empty, and an overrun when the host writes while storage is full. Pulling the enable low, or applying reset, discards everything.

Top module: `pfifo_top`

## Requirements
- R1: The storage depth `DEPTH` is a build-time parameter of 4, 8 or 16 words (default 8). The block holds at most `DEPTH` words.
- R2: Each stored word produces two slot values in this order:
  - bits 15:0 first;
  - bits 31:16 second.
- R3: A slot value is 20 bits wide. It carries the sample in bits 19:4, and bits 3:0 are zero.
- R4: `thr_hit` is high while the number of free words is at least (`thr_sel`+1)*`DEPTH`/4. With `DEPTH`=8, `thr_sel` values 0, 1, 2 and 3 select 2, 4, 6 and 8 free words. `thr_hit` follows the stored count in the same cycle that the count changes.
- R5: A slot request made while storage is empty returns `slot_vld` with `slot_data` equal to 0 on the next cycle, and sets the sticky `underrun` flag.
- R6: A starved request does not advance the read position. The next slot returned after a word is written is the low half of that word.
- R7: A write while `DEPTH` words are stored is dropped and sets the sticky `overrun` flag. The stored words and their order do not change.
- R8: `dma_req` rises one cycle after `thr_hit` is seen high. It stays high until a `dma_ack` pulse, and it is low in the cycle after that pulse. It rises again one cycle later only if `thr_hit` is still high.
- R9: While `en` is low, the block does the following:
  - storage is emptied;
  - both flags and `dma_req` are cleared;
  - writes and slot requests are ignored;
  - unpacking restarts from the low half of the next word written.
- R10: `slot_vld` is a one-cycle pulse in the cycle after each enabled `slot_req`. It is low otherwise.
- R11: During reset the block holds the following:
  - `slot_vld`, `slot_data`, `underrun`, `overrun` and `dma_req` are all 0;
  - storage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable; low clears the channel |
| thr_sel | input | 2 | Free-space level select for threshold and DMA request |
| wr_stb | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 32 | Host word: two packed 16-bit samples |
| slot_req | input | 1 | Frame side asks for the next sample |
| slot_vld | output | 1 | Slot value valid, one cycle after the request |
| slot_data | output | 20 | Left-justified slot value |
| thr_hit | output | 1 | Free space is at or above the selected level |
| underrun | output | 1 | Sticky: a sample was requested while storage was empty |
| overrun | output | 1 | Sticky: a write arrived while storage was full |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | One-cycle DMA acknowledge |

## Verification
The hardest state to reach is full storage with a half-consumed word at the head. At that point overrun, threshold and unpack order all interact. The bench fills all eight words one after another, pushes a ninth word, and then drains all sixteen samples. This shows that the dropped word never comes out and that the request after draining starves. The DMA handshake is checked twice: with free space still above the level, so the request re-raises, and with storage nearly full, so it stays down after the acknowledge.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  localparam int WORD_W = 32;
  localparam int SAMP_W = 16;
  localparam int PAD_W  = 4;
  localparam int SLOT_W = SAMP_W + PAD_W;

  // left-justify a sample inside a slot
  function automatic logic [SLOT_W-1:0] to_slot(input logic [SAMP_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction

  // free words needed before the threshold status rises
  function automatic int unsigned level_words(input logic [1:0] sel, input int unsigned depth);
    return ((int'(sel) + 1) * depth) / 4;
  endfunction
endpackage

// File: rtl/pfifo_store.sv
module pfifo_store #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [AW:0]   count
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  assign head  = mem[rptr[AW-1:0]];
  assign count = wptr - rptr;
endmodule

// File: rtl/pfifo_unpack.sv
module pfifo_unpack
  import pfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req,
  input  logic              have_word,
  input  logic [WORD_W-1:0] word,
  output logic              pop,
  output logic              starve,
  output logic              slot_vld,
  output logic [SLOT_W-1:0] slot_data
);
  logic              upper;
  logic [SAMP_W-1:0] samp;

  assign samp   = word[(upper ? SAMP_W : 0) +: SAMP_W];
  assign starve = req && !have_word;
  assign pop    = req && have_word && upper;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      upper     <= 1'b0;
      slot_vld  <= 1'b0;
      slot_data <= '0;
    end else begin
      slot_vld <= req;
      if (req) begin
        if (have_word) begin
          slot_data <= to_slot(samp);
          upper     <= !upper;
        end else begin
          slot_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pfifo_status.sv
module pfifo_status
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [AW:0] count,
  input  logic [1:0]  thr_sel,
  input  logic        wr_drop,
  input  logic        rd_starve,
  input  logic        dma_ack,
  output logic        thr_hit,
  output logic        underrun,
  output logic        overrun,
  output logic        dma_req
);
  logic [AW:0] free_w;

  assign free_w  = (AW+1)'(DEPTH) - count;
  assign thr_hit = 32'(free_w) >= level_words(thr_sel, DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (rd_starve) underrun <= 1'b1;
      if (wr_drop)   overrun  <= 1'b1;
      if (dma_ack)   dma_req  <= 1'b0;
      else if (thr_hit) dma_req <= 1'b1;
    end
  end
endmodule

// File: rtl/pfifo_top.sv
module pfifo_top
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        thr_sel,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              slot_req,
  output logic              slot_vld,
  output logic [SLOT_W-1:0] slot_data,
  output logic              thr_hit,
  output logic              underrun,
  output logic              overrun,
  output logic              dma_req,
  input  logic              dma_ack
);
  logic              clr, full, push_ok, wr_drop, pop_word, rd_starve, rd_req;
  logic [AW:0]       word_cnt;
  logic [WORD_W-1:0] head;

  assign clr     = !en;
  assign full    = word_cnt == (AW+1)'(DEPTH);
  assign push_ok = en && wr_stb && !full;
  assign wr_drop = en && wr_stb && full;
  assign rd_req  = en && slot_req;

  pfifo_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(push_ok), .wdata(wr_data), .pop(pop_word),
    .head(head), .count(word_cnt)
  );

  pfifo_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .req(rd_req), .have_word(word_cnt != '0), .word(head),
    .pop(pop_word), .starve(rd_starve),
    .slot_vld(slot_vld), .slot_data(slot_data)
  );

  pfifo_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .count(word_cnt), .thr_sel(thr_sel),
    .wr_drop(wr_drop), .rd_starve(rd_starve), .dma_ack(dma_ack),
    .thr_hit(thr_hit), .underrun(underrun), .overrun(overrun), .dma_req(dma_req)
  );
endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        slot_req,
  input logic        slot_vld,
  input logic [19:0] slot_data,
  input logic        underrun,
  input logic        overrun,
  input logic        dma_req,
  input logic        dma_ack,
  input logic        rd_starve,
  input logic        wr_drop,
  input logic [AW:0] word_cnt
);
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= (AW+1)'(DEPTH));
  // R3
  slot_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> slot_data[3:0] == 4'h0);
  // R5
  starve_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_starve |=> (slot_vld && slot_data == 20'h0 && underrun));
  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> overrun);
  // R8
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && en) |=> dma_req);
  // R8
  dma_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req);
  // R9
  disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (word_cnt == '0 && !underrun && !overrun && !dma_req));
  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slot_req) |=> slot_vld);
  // R10
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && slot_req) |=> !slot_vld);
endmodule

bind pfifo_top pfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .slot_req(slot_req),
  .slot_vld(slot_vld), .slot_data(slot_data),
  .underrun(underrun), .overrun(overrun),
  .dma_req(dma_req), .dma_ack(dma_ack),
  .rd_starve(rd_starve), .wr_drop(wr_drop), .word_cnt(word_cnt)
);

// File: tb/pfifo_top_bench.sv
module pfifo_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  thr_sel = 2'd0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_data = '0;
  logic        slot_req = 1'b0;
  logic        slot_vld;
  logic [19:0] slot_data;
  logic        thr_hit, underrun, overrun, dma_req;
  logic        dma_ack = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pfifo_top u_pfifo_top (
    .clk(clk), .rst_n(rst_n), .en(en), .thr_sel(thr_sel),
    .wr_stb(wr_stb), .wr_data(wr_data), .slot_req(slot_req),
    .slot_vld(slot_vld), .slot_data(slot_data), .thr_hit(thr_hit),
    .underrun(underrun), .overrun(overrun), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  // {is_write, data, expected slot}
  localparam int NV = 9;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 32'hBEEF_1234, 20'h0},
    {1'b1, 32'h00FF_8001, 20'h0},
    {1'b1, 32'hA5A5_0000, 20'h0},
    {1'b0, 32'h0, 20'h12340},
    {1'b0, 32'h0, 20'hBEEF0},
    {1'b0, 32'h0, 20'h80010},
    {1'b0, 32'h0, 20'h00FF0},
    {1'b0, 32'h0, 20'h00000},
    {1'b0, 32'h0, 20'hA5A50}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_stb = 1'b1; wr_data = d;
    tick();
    wr_stb = 1'b0;
  endtask

  // request at one edge, result visible after the next
  task automatic read_slot(output logic v, output logic [19:0] d);
    slot_req = 1'b1;
    tick();
    slot_req = 1'b0;
    v = slot_vld; d = slot_data;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic        v;
    logic [19:0] d;
    #1;
    rst_n = 1'b0; en = 1'b1;
    tick(); tick();
    // R11 reset state
    check("R11 vld", {31'b0, slot_vld}, 0);
    check("R11 flags", {29'b0, underrun, overrun, dma_req}, 0);
    check("R11 data", {12'b0, slot_data}, 0);
    rst_n = 1'b1;

    // R2 R3 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) write_word(VEC[i][51:20]);
      else begin
        read_slot(v, d);
        check("R2/R3 slot", {12'b0, d}, {12'b0, VEC[i][19:0]});
        check("R10 vld", {31'b0, v}, 1);
      end
    end
    check("R10 vld drop", {31'b0, slot_vld}, 0);

    // R5 R6 underrun then pointer holds
    read_slot(v, d);
    check("R5 starve data", {11'b0, v, d}, {11'b0, 1'b1, 20'h0});
    check("R5 underrun", {31'b0, underrun}, 1);
    write_word(32'h5555_AAAA);
    read_slot(v, d);
    check("R6 next low half", {12'b0, d}, 32'h000AAAA0);

    // R9 disable clears and restarts low half
    write_word(32'h1111_2222);
    write_word(32'h3333_4444);
    read_slot(v, d);
    check("R9 pre", {12'b0, d}, 32'h5555_0);
    read_slot(v, d);
    check("R9 pre2", {12'b0, d}, 32'h2222_0);
    en = 1'b0; tick(); en = 1'b1;
    check("R9 flags clear", {30'b0, underrun, overrun}, 0);
    write_word(32'h7777_8888);
    read_slot(v, d);
    check("R9 restart low", {12'b0, d}, 32'h8888_0);
    read_slot(v, d);
    check("R9 high", {12'b0, d}, 32'h7777_0);
    read_slot(v, d);
    check("R9 old gone", {12'b0, d}, 0);

    // R1 R4 R7 fill, overrun, drain
    do_reset();
    thr_sel = 2'd3;
    check("R4 sel3 empty", {31'b0, thr_hit}, 1);
    write_word(32'h0001_0000);
    check("R4 sel3 one word", {31'b0, thr_hit}, 0);
    thr_sel = 2'd1;
    for (int i = 1; i < 8; i++) begin
      write_word({16'(2*i+1), 16'(2*i)});
      if (i == 3) check("R4 sel1 free4", {31'b0, thr_hit}, 1);
      if (i == 4) check("R4 sel1 free3", {31'b0, thr_hit}, 0);
    end
    check("R7 no overrun yet", {31'b0, overrun}, 0);
    write_word(32'hDEAD_DEAD);
    check("R7 overrun", {31'b0, overrun}, 1);
    for (int i = 0; i < 16; i++) begin
      read_slot(v, d);
      check("R1/R7 drain", {12'b0, d}, {12'b0, 16'(i), 4'h0});
    end
    read_slot(v, d);
    check("R7 dropped word absent", {12'b0, d}, 0);
    check("R5 underrun after drain", {31'b0, underrun}, 1);

    // R8 dma handshake
    do_reset();
    thr_sel = 2'd0;
    tick();
    check("R8 req up", {31'b0, dma_req}, 1);
    tick(); tick();
    check("R8 req held", {31'b0, dma_req}, 1);
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    check("R8 ack clears", {31'b0, dma_req}, 0);
    tick();
    check("R8 re-raise", {31'b0, dma_req}, 1);
    for (int i = 0; i < 7; i++) write_word(32'h0);
    check("R4 sel0 free1", {31'b0, thr_hit}, 0);
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    tick(); tick();
    check("R8 stays low", {31'b0, dma_req}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule